// File: doc/BRIEF.md
# Two-Level Translation Table Walker

The walker turns a 32-bit virtual address into a physical address by reading descriptors from a two-level table in memory. A request is taken only while the walker is idle. If the address falls below 0x02000000, a per-process offset is added to it first. When translation is switched off, the remapped address comes back unchanged and no memory read is made. When translation is on, one first-level descriptor is read. That descriptor either maps a 1 MB section directly or points at a coarse or fine second-level table. A second-level descriptor maps a 64 KB, 4 KB or 1 KB page.

Descriptor reads use a single-beat port. A one-cycle request strobe starts each read, the address is held, and the walker waits any number of cycles for the valid strobe. Each walk ends with a one-cycle done pulse. The result carries the physical address, the two access-permission bits, the domain, a status code and a fault flag, and it stays on the outputs until the next walk finishes. The permission decision itself belongs to a separate checker that reads the ap and domain outputs.

Top module: `tt_walker`

## Requirements
- R1: When the request address is below 0x02000000, the process offset `ctl_pid` is added to it, modulo 2^32, before translation or pass-through. Addresses at or above that limit are used unchanged.
- R2: With `ctl_enable` low, the done pulse comes one cycle after the request is accepted. The physical address is the remapped address, `rsp_bypass` is 1, `rsp_fault` is 0, status is 0 and no memory read is issued.
- R3: The first descriptor is read at {ctl_base[31:14], va[31:20], 2'b00}.
- R4: A first-level descriptor with bits [1:0] = 0 ends the walk with fault = 1, status 5 and domain 0, after a single read.
- R5: A first-level descriptor with bits [1:0] = 2 maps a section with PA = {desc[31:20], va[19:0]}, ap = desc[11:10], domain = desc[8:5] and status 13, after a single read.
- R6: A first-level type of 1 selects a coarse table, whose second read is at {desc[31:10], va[19:12], 2'b00}. A type of 3 selects a fine table, whose second read is at {desc[31:12], va[19:10], 2'b00}.
- R7: A second-level descriptor with bits [1:0] = 0 ends the walk with fault = 1, status 7 and domain 0.
- R8: Second-level type 1 gives PA = {d[31:16], va[15:0]}, type 2 gives {d[31:12], va[11:0]} and type 3 gives {d[31:10], va[9:0]}.
- R9: For second-level types 1 and 2, ap is d[5:4], d[7:6], d[9:8] or d[11:10] as va[15:14] is 0, 1, 2 or 3. For type 3, ap is d[5:4].
- R10: A completed page walk reports status 15, the domain from first-level bits [8:5] and fault = 0. `rsp_code` is always {domain, status}.
- R11: Each descriptor read raises `mem_req` for exactly one cycle. `mem_addr` then holds until `mem_valid` arrives, whatever the number of wait cycles.
- R12: `req_ready` is high only when idle, and a request made while busy is ignored. `rsp_done` is a one-cycle pulse, and the response outputs stay unchanged until the next walk completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Translation request |
| req_va | input | 32 | Virtual address |
| req_ready | output | 1 | Walker idle, request accepted |
| ctl_enable | input | 1 | Translation enable |
| ctl_base | input | 32 | First-level table base |
| ctl_pid | input | 32 | Offset added to low addresses |
| mem_req | output | 1 | Descriptor read strobe |
| mem_addr | output | 32 | Descriptor address |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Descriptor word |
| rsp_done | output | 1 | Walk complete pulse |
| rsp_pa | output | 32 | Physical address |
| rsp_ap | output | 2 | Access-permission bits |
| rsp_dom | output | 4 | Domain |
| rsp_status | output | 4 | Status code |
| rsp_fault | output | 1 | Translation fault |
| rsp_bypass | output | 1 | Translation off, read/write granted |
| rsp_code | output | 8 | {domain, status} |

## Verification
The assertions check the following on every cycle:
- the memory strobe is a single cycle and its address holds until data returns;
- done is a single pulse and the response holds after it;
- every fault reports status 5 or 7 with domain 0, and every successful translation reports 13 or 15;
- a pass-through result always follows its request by one cycle.

The directed scenarios are the only way to show the address arithmetic. This covers the offset remapping, both table-address formulas, the page-size splits of the physical address and the selection of sub-page ap bits. It also covers ignoring a request while busy, and the latencies of zero and of many wait cycles.

// File: rtl/tt_walker.sv
module tt_walker #(
  parameter logic [31:0] LOW_LIMIT = 32'h0200_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [31:0] req_va,
  output logic        req_ready,
  input  logic        ctl_enable,
  input  logic [31:0] ctl_base,
  input  logic [31:0] ctl_pid,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_valid,
  input  logic [31:0] mem_rdata,
  output logic        rsp_done,
  output logic [31:0] rsp_pa,
  output logic [1:0]  rsp_ap,
  output logic [3:0]  rsp_dom,
  output logic [3:0]  rsp_status,
  output logic        rsp_fault,
  output logic        rsp_bypass,
  output logic [7:0]  rsp_code
);

  typedef enum logic [2:0] {S_IDLE, S_L1_REQ, S_L1_WAIT, S_L2_REQ, S_L2_WAIT, S_DONE} state_t;

  state_t      state;
  logic [31:0] va;
  logic [21:0] l1_tab;
  logic        l1_fine;
  logic [3:0]  l1_dom;
  logic [31:0] va_in, l1_addr, l2_addr;
  logic [1:0]  ap_sel;
  logic        unused_bits;

  assign va_in       = (req_va < LOW_LIMIT) ? req_va + ctl_pid : req_va;
  assign l1_addr     = {ctl_base[31:14], va[31:20], 2'b00};
  assign l2_addr     = l1_fine ? {l1_tab[21:2], va[19:10], 2'b00}
                               : {l1_tab, va[19:12], 2'b00};
  assign unused_bits = ^{mem_rdata[3:2], ctl_base[13:0]};

  assign req_ready = (state == S_IDLE);
  assign mem_req   = (state == S_L1_REQ) || (state == S_L2_REQ);
  assign mem_addr  = (state == S_L1_REQ || state == S_L1_WAIT) ? l1_addr : l2_addr;
  assign rsp_done  = (state == S_DONE);
  assign rsp_code  = {rsp_dom, rsp_status};

  always_comb begin
    case (va[15:14])
      2'd0:    ap_sel = mem_rdata[5:4];
      2'd1:    ap_sel = mem_rdata[7:6];
      2'd2:    ap_sel = mem_rdata[9:8];
      default: ap_sel = mem_rdata[11:10];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      va         <= '0;
      l1_tab     <= '0;
      l1_fine    <= 1'b0;
      l1_dom     <= '0;
      rsp_pa     <= '0;
      rsp_ap     <= '0;
      rsp_dom    <= '0;
      rsp_status <= '0;
      rsp_fault  <= 1'b0;
      rsp_bypass <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          va <= va_in;
          if (ctl_enable) state <= S_L1_REQ;
          else begin
            rsp_pa     <= va_in;
            rsp_ap     <= 2'b00;
            rsp_dom    <= 4'd0;
            rsp_status <= 4'd0;
            rsp_fault  <= 1'b0;
            rsp_bypass <= 1'b1;
            state      <= S_DONE;
          end
        end
        S_L1_REQ: state <= S_L1_WAIT;
        S_L1_WAIT: if (mem_valid) begin
          case (mem_rdata[1:0])
            2'd0: begin
              rsp_pa <= '0; rsp_ap <= 2'b00; rsp_dom <= 4'd0;
              rsp_status <= 4'd5; rsp_fault <= 1'b1; rsp_bypass <= 1'b0;
              state <= S_DONE;
            end
            2'd2: begin
              rsp_pa <= {mem_rdata[31:20], va[19:0]};
              rsp_ap <= mem_rdata[11:10]; rsp_dom <= mem_rdata[8:5];
              rsp_status <= 4'd13; rsp_fault <= 1'b0; rsp_bypass <= 1'b0;
              state <= S_DONE;
            end
            default: begin
              l1_tab  <= mem_rdata[31:10];
              l1_fine <= mem_rdata[1];
              l1_dom  <= mem_rdata[8:5];
              state   <= S_L2_REQ;
            end
          endcase
        end
        S_L2_REQ: state <= S_L2_WAIT;
        S_L2_WAIT: if (mem_valid) begin
          rsp_bypass <= 1'b0;
          state      <= S_DONE;
          case (mem_rdata[1:0])
            2'd0: begin
              rsp_pa <= '0; rsp_ap <= 2'b00; rsp_dom <= 4'd0;
              rsp_status <= 4'd7; rsp_fault <= 1'b1;
            end
            2'd1: begin
              rsp_pa <= {mem_rdata[31:16], va[15:0]}; rsp_ap <= ap_sel;
              rsp_dom <= l1_dom; rsp_status <= 4'd15; rsp_fault <= 1'b0;
            end
            2'd2: begin
              rsp_pa <= {mem_rdata[31:12], va[11:0]}; rsp_ap <= ap_sel;
              rsp_dom <= l1_dom; rsp_status <= 4'd15; rsp_fault <= 1'b0;
            end
            default: begin
              rsp_pa <= {mem_rdata[31:10], va[9:0]}; rsp_ap <= mem_rdata[5:4];
              rsp_dom <= l1_dom; rsp_status <= 4'd15; rsp_fault <= 1'b0;
            end
          endcase
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r11_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
  a_r11_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> $stable(mem_addr));
  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
  a_r12_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> $stable(rsp_pa) && $stable(rsp_code) && $stable(rsp_fault) && $stable(rsp_ap));
  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req && !rsp_done);
  a_r4_r7_fault_code: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done && rsp_fault |-> (rsp_status == 4'd5 || rsp_status == 4'd7) && rsp_dom == 4'd0);
  a_r10_ok_status: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done && !rsp_fault && !rsp_bypass |-> (rsp_status == 4'd13 || rsp_status == 4'd15));
  a_r2_bypass_timing: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done && rsp_bypass |-> !rsp_fault && $past(req_valid && req_ready));

endmodule

// File: tb/test_tt_walker.sv
`timescale 1ns/1ps
module test_tt_walker;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, ctl_enable = 0, mem_valid = 0;
  logic [31:0] req_va = 0, ctl_base = 32'h0010_0000, ctl_pid = 0, mem_rdata = 0;
  logic req_ready, mem_req, rsp_done, rsp_fault, rsp_bypass;
  logic [31:0] mem_addr, rsp_pa;
  logic [1:0] rsp_ap;
  logic [3:0] rsp_dom, rsp_status;
  logic [7:0] rsp_code;

  tt_walker i_tt_walker (.*);

  always #4 clk = ~clk;

  int checks = 0, errs = 0, reads = 0, lat = 2, pend = 0;
  bit busy = 0;
  logic [31:0] cap;
  logic [31:0] mem [logic [31:0]];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    mem_valid = 0;
    if (busy) begin
      if (pend == 0) begin
        mem_valid = 1;
        mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
        busy = 0;
        checks++;
        if (mem_addr !== cap) begin
          errs++;
          $display("FAIL R11 addr held actual=%h expected=%h", mem_addr, cap);
        end
      end else pend--;
    end
    if (mem_req) begin cap = mem_addr; pend = lat; busy = 1; reads++; end
  end

  function automatic logic [31:0] l1a(logic [31:0] va);
    return {ctl_base[31:14], va[31:20], 2'b00};
  endfunction

  task automatic walk(string tag, logic [31:0] va, logic [31:0] epa, logic [1:0] eap,
                      logic [3:0] edom, logic [3:0] est, bit efault, bit ebyp, int ereads);
    int n = 0;
    int r0 = reads;
    @(negedge clk); req_valid = 1; req_va = va;
    @(negedge clk); req_valid = 0;
    while (!rsp_done && n < 500) begin @(negedge clk); n++; end
    chk({tag, " done"}, rsp_done, 1);
    chk({tag, " pa"}, rsp_pa, epa);
    chk({tag, " ap"}, rsp_ap, eap);
    chk({tag, " dom"}, rsp_dom, edom);
    chk({tag, " status"}, rsp_status, est);
    chk({tag, " fault"}, rsp_fault, efault);
    chk({tag, " bypass"}, rsp_bypass, ebyp);
    chk({tag, " code R10"}, rsp_code, {edom, est});
    chk({tag, " reads"}, reads - r0, ereads);
    if (ebyp) chk({tag, " R2 latency"}, n, 0);
    @(negedge clk);
    chk({tag, " R12 done pulse"}, rsp_done, 0);
    chk({tag, " R12 hold pa"}, rsp_pa, epa);
  endtask

  task automatic t_reset;
    chk("reset R12 ready", req_ready, 1);
    chk("reset R12 done", rsp_done, 0);
    chk("reset R11 mem_req", mem_req, 0);
  endtask

  task automatic t_bypass;
    ctl_enable = 0; ctl_pid = 32'h0400_0000;
    walk("R1 R2 low remap", 32'h0123_4567, 32'h0523_4567, 0, 0, 0, 0, 1, 0);
    walk("R1 R2 high unchanged", 32'h0300_0010, 32'h0300_0010, 0, 0, 0, 0, 1, 0);
    walk("R1 R2 edge below", 32'h01FF_FFFF, 32'h05FF_FFFF, 0, 0, 0, 0, 1, 0);
    ctl_pid = 0;
  endtask

  task automatic t_section;
    logic [31:0] va = 32'h1234_5678;
    ctl_enable = 1; lat = 3;
    mem[l1a(va)] = 32'hABC0_0000 | (3 << 10) | (5 << 5) | 2;
    walk("R3 R5 section", va, 32'hABC4_5678, 3, 5, 13, 0, 0, 1);
    walk("R4 section fault", 32'h2000_0000, 0, 0, 0, 5, 1, 0, 1);
  endtask

  task automatic t_coarse;
    logic [31:0] va = 32'h4000_6ABC;
    logic [31:0] d1 = 32'h0020_0400 | (9 << 5) | 1;
    logic [31:0] vb = 32'h4001_C123;
    mem[l1a(va)] = d1;
    mem[{d1[31:10], va[19:12], 2'b00}] = 32'h7777_7000 | 32'hE40 | 2;
    walk("R6 R8 R9 coarse small", va, 32'h7777_7ABC, 1, 9, 15, 0, 0, 2);
    mem[{d1[31:10], vb[19:12], 2'b00}] = 32'h8888_0000 | 32'hE40 | 1;
    walk("R6 R8 R9 coarse large", vb, 32'h8888_C123, 3, 9, 15, 0, 0, 2);
  endtask

  task automatic t_fine;
    logic [31:0] va = 32'h5000_0ABC;
    logic [31:0] d1 = 32'h0030_0000 | (2 << 5) | 3;
    mem[l1a(va)] = d1;
    mem[{d1[31:12], va[19:10], 2'b00}] = 32'h9999_9C00 | (2 << 4) | 3;
    walk("R6 R8 R9 fine tiny", va, 32'h9999_9EBC, 2, 2, 15, 0, 0, 2);
    walk("R7 page fault", 32'h5000_1000, 0, 0, 0, 7, 1, 0, 2);
  endtask

  task automatic t_remap_on;
    logic [31:0] vr = 32'h0410_0000;
    ctl_pid = 32'h0400_0000;
    mem[l1a(vr)] = 32'h0DE0_0000 | (1 << 10) | (4 << 5) | 2;
    walk("R1 remap with walk", 32'h0010_0020, 32'h0DE0_0020, 1, 4, 15 - 2, 0, 0, 1);
    ctl_pid = 0;
  endtask

  task automatic t_latency;
    lat = 0;
    walk("R11 zero wait", 32'h1234_5678, 32'hABC4_5678, 3, 5, 13, 0, 0, 1);
    lat = 20;
    walk("R11 long wait", 32'h4000_6ABC, 32'h7777_7ABC, 1, 9, 15, 0, 0, 2);
  endtask

  task automatic t_busy;
    int n = 0;
    lat = 10;
    @(negedge clk); req_valid = 1; req_va = 32'h1234_5678;
    @(negedge clk); req_valid = 0;
    @(negedge clk); @(negedge clk);
    chk("R12 busy not ready", req_ready, 0);
    req_valid = 1; req_va = 32'h4000_6ABC;
    @(negedge clk); req_valid = 0;
    while (!rsp_done && n < 500) begin @(negedge clk); n++; end
    chk("R12 busy ignore pa", rsp_pa, 32'hABC4_5678);
    chk("R12 busy ignore status", rsp_status, 13);
    @(negedge clk);
    chk("R12 back to idle", req_ready, 1);
    @(negedge clk);
    chk("R12 no second walk", mem_req | rsp_done, 0);
    lat = 2;
  endtask

  initial begin
    #(8 * 150000);
    errs++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_bypass;
    t_section;
    t_coarse;
    t_fine;
    t_remap_on;
    t_latency;
    t_busy;
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
    $finish;
  end
endmodule